// File: doc/BRIEF.md
# SPI Register Access Engine

This block is a 4-wire SPI slave that gives an external host byte-wide access to a 256-entry internal register file. The host selects the block by pulling chip select low and then exchanges 8-bit bytes, most significant bit first. The first byte of each access is a command. Four commands are recognised: one clears the serial engine's pointer, one loads the pointer from the byte that follows, one opens a write stream and one opens a read stream. Every data byte of a stream uses the register at the current pointer, and the pointer then advances by one.

The link is full duplex. For every byte the host clocks in, the block clocks out the register at the pointer as it stood when that byte began. SCLK and the data lines idle high. The block samples MOSI on the rising SCLK edge and updates MISO on the falling edge, which is SPI mode 3. All pins are synchronised into the system clock domain. SCLK high and low phases must each last at least six system clock cycles. Data flows only through the serial pins, so there is no valid/ready stream at the block edge and back-pressure does not arise. The host paces every transfer through SCLK.

Top module: `spi_reg_engine`

## Requirements
- R1: After reset all 256 registers read as 0x00, the pointer is 0x00 and MISO is high.
- R2: Bytes move MSB first. MOSI is taken on rising SCLK, MISO changes only on falling SCLK, and MISO is high whenever chip select is high.
- R3: Command 0x7D loads the pointer from the next byte. The engine then returns to the command phase within the same selection.
- R4: Command 0x7E stores each following byte at the pointer and increments the pointer after each store, until chip select rises.
- R5: Command 0x7F returns, in each following byte, the register at the pointer and increments the pointer after each byte, until chip select rises.
- R6: In every byte, including command bytes, MISO carries the register addressed by the pointer at the start of that byte.
- R7: The pointer is 8 bits wide and steps from 0xFF to 0x00.
- R8: Command 0x7A sets the pointer to 0x00, leaves the registers unchanged and keeps the engine in the command phase.
- R9: In the command phase, any byte other than 0x7A, 0x7D, 0x7E or 0x7F changes neither the pointer nor any register.
- R10: If chip select rises in the middle of a byte, that byte is dropped and the next selection starts in the command phase. The pointer keeps its value across selections.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from the host, idles high |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host, high while deselected |

## Verification
Directed frames write values with only the top bit set and with only the bottom bit set, then read them back. A reversed bit order or a wrong sampling edge therefore shows up as a different byte. Further directed frames cover the pointer wrap, the pointer-clear command, a run of unknown codes and a selection dropped mid-byte. Each is followed by a read that separates "no effect" from "pointer moved" or "register written". Seeded random frames mix all command types, random pointer targets and random stream lengths, with occasional aborted bytes. Every returned byte, command bytes included, is compared against a bench model of the pointer and the register array, so a stale pointer or a missed store is detected on the very next byte.

// File: rtl/spi_reg_pkg.sv
`timescale 1ns/1ps
package spi_reg_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W);

  localparam logic [BYTE_W-1:0] OP_CLR_PTR = 8'h7A;
  localparam logic [BYTE_W-1:0] OP_SET_PTR = 8'h7D;
  localparam logic [BYTE_W-1:0] OP_WRITE   = 8'h7E;
  localparam logic [BYTE_W-1:0] OP_READ    = 8'h7F;

  typedef enum logic [1:0] {
    PH_CMD,
    PH_PTR,
    PH_WR,
    PH_RD
  } phase_t;
endpackage

// File: rtl/spi_pin_sync.sv
`timescale 1ns/1ps
module spi_pin_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= '1;
        else        stage_q[g] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= '1;
        else        stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/spi_bit_shifter.sv
`timescale 1ns/1ps
module spi_bit_shifter
  import spi_reg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_active,
  input  logic              sclk_s,
  input  logic              mosi_s,
  input  logic [BYTE_W-1:0] tx_byte,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              rx_valid,
  output logic              miso,
  output logic              sclk_rise,
  output logic              sclk_fall
);
  logic              sclk_prev;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] rx_shift;
  logic [BYTE_W-1:0] tx_shift;
  logic              miso_q;

  assign sclk_rise = sclk_s & ~sclk_prev;
  assign sclk_fall = ~sclk_s & sclk_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_prev <= 1'b1;
    else        sclk_prev <= sclk_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt  <= '0;
      rx_shift <= '0;
      tx_shift <= '1;
      miso_q   <= 1'b1;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (!cs_active) begin
        bit_cnt  <= '0;
        tx_shift <= '1;
        miso_q   <= 1'b1;
      end else begin
        if (sclk_rise) begin
          rx_shift <= {rx_shift[BYTE_W-2:0], mosi_s};
          bit_cnt  <= bit_cnt + CNT_W'(1);
          if (bit_cnt == CNT_W'(BYTE_W-1)) rx_valid <= 1'b1;
        end
        if (sclk_fall) begin
          if (bit_cnt == '0) begin
            miso_q   <= tx_byte[BYTE_W-1];
            tx_shift <= {tx_byte[BYTE_W-2:0], 1'b1};
          end else begin
            miso_q   <= tx_shift[BYTE_W-1];
            tx_shift <= {tx_shift[BYTE_W-2:0], 1'b1};
          end
        end
      end
    end
  end

  assign rx_byte = rx_shift;
  assign miso    = miso_q;
endmodule

// File: rtl/spi_cmd_ctrl.sv
`timescale 1ns/1ps
module spi_cmd_ctrl
  import spi_reg_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_active,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic [ADDR_W-1:0] ptr,
  output phase_t            phase,
  output logic              wr_en,
  output logic [BYTE_W-1:0] wr_data
);
  always_comb begin
    wr_en   = rx_valid && cs_active && (phase == PH_WR);
    wr_data = rx_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_CMD;
      ptr   <= '0;
    end else if (!cs_active) begin
      phase <= PH_CMD;
    end else if (rx_valid) begin
      unique case (phase)
        PH_CMD: begin
          unique case (rx_byte)
            OP_CLR_PTR: ptr   <= '0;
            OP_SET_PTR: phase <= PH_PTR;
            OP_WRITE:   phase <= PH_WR;
            OP_READ:    phase <= PH_RD;
            default:    ;
          endcase
        end
        PH_PTR: begin
          ptr   <= rx_byte[ADDR_W-1:0];
          phase <= PH_CMD;
        end
        PH_WR, PH_RD: ptr <= ptr + ADDR_W'(1);
        default: phase <= PH_CMD;
      endcase
    end
  end
endmodule

// File: rtl/spi_regfile.sv
`timescale 1ns/1ps
module spi_regfile #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[addr] <= wr_data;
    end
  end

  assign rd_data = mem[addr];
endmodule

// File: rtl/spi_reg_engine.sv
`timescale 1ns/1ps
module spi_reg_engine
  import spi_reg_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_sclk,
  input  logic spi_cs_n,
  input  logic spi_mosi,
  output logic spi_miso
);
  logic [2:0]        pins_s;
  logic              cs_active;
  logic              sclk_rise;
  logic              sclk_fall;
  logic              rx_valid;
  logic [BYTE_W-1:0] rx_byte;
  logic [BYTE_W-1:0] rd_data;
  logic [BYTE_W-1:0] wr_data;
  logic              wr_en;
  logic [ADDR_W-1:0] ptr;
  phase_t            phase;

  spi_pin_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) sync_i (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({spi_cs_n, spi_sclk, spi_mosi}),
    .dout (pins_s)
  );

  assign cs_active = ~pins_s[2];

  spi_bit_shifter shift_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_active(cs_active),
    .sclk_s   (pins_s[1]),
    .mosi_s   (pins_s[0]),
    .tx_byte  (rd_data),
    .rx_byte  (rx_byte),
    .rx_valid (rx_valid),
    .miso     (spi_miso),
    .sclk_rise(sclk_rise),
    .sclk_fall(sclk_fall)
  );

  spi_cmd_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_active(cs_active),
    .rx_valid (rx_valid),
    .rx_byte  (rx_byte),
    .ptr      (ptr),
    .phase    (phase),
    .wr_en    (wr_en),
    .wr_data  (wr_data)
  );

  spi_regfile #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W)) regs_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .addr   (ptr),
    .wr_data(wr_data),
    .rd_data(rd_data)
  );
endmodule

// File: rtl/spi_reg_engine_chk.sv
`timescale 1ns/1ps
module spi_reg_engine_chk
  import spi_reg_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_active,
  input logic              sclk_fall,
  input logic              rx_valid,
  input logic              wr_en,
  input phase_t            phase,
  input logic [ADDR_W-1:0] ptr,
  input logic              spi_miso
);
  assert_miso_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_active |=> spi_miso);

  assert_miso_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_active && !sclk_fall) |=> $stable(spi_miso));

  assert_wr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (ptr == $past(ptr) + ADDR_W'(1)));

  assert_rd_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && cs_active && phase == PH_RD) |=> (ptr == $past(ptr) + ADDR_W'(1)));

  assert_ptr_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |=> $stable(ptr));

  assert_cmd_on_deselect_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_active |=> (phase == PH_CMD));
endmodule

bind spi_reg_engine spi_reg_engine_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .cs_active(cs_active),
  .sclk_fall(sclk_fall),
  .rx_valid (rx_valid),
  .wr_en    (wr_en),
  .phase    (phase),
  .ptr      (ptr),
  .spi_miso (spi_miso)
);

// File: tb/spi_reg_engine_tb.sv
`timescale 1ns/1ps
module spi_reg_engine_tb_top;
  localparam int HALF_NS = 30;
  localparam int WD_NS   = 900000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b1;
  logic cs_n = 1'b1;
  logic mosi = 1'b1;
  logic miso;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0] model_mem [256];
  logic [7:0] mptr = 8'h00;
  int         mphase = 0; // 0 cmd, 1 ptr, 2 write, 3 read

  always #2.5 clk = ~clk;

  spi_reg_engine dut_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .spi_sclk(sclk),
    .spi_cs_n(cs_n),
    .spi_mosi(mosi),
    .spi_miso(miso)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] model_expect();
    return model_mem[mptr];
  endfunction

  function automatic string phase_tag();
    case (mphase)
      2: return "R4";
      3: return "R5";
      default: return "R6";
    endcase
  endfunction

  function automatic void model_apply(input logic [7:0] b);
    case (mphase)
      0: begin
        if (b == 8'h7A) mptr = 8'h00;
        else if (b == 8'h7D) mphase = 1;
        else if (b == 8'h7E) mphase = 2;
        else if (b == 8'h7F) mphase = 3;
      end
      1: begin mptr = b; mphase = 0; end
      2: begin model_mem[mptr] = b; mptr = mptr + 8'h01; end
      default: mptr = mptr + 8'h01;
    endcase
  endfunction

  task automatic frame_begin();
    cs_n = 1'b0;
    #(HALF_NS);
  endtask

  task automatic frame_end();
    cs_n = 1'b1;
    mphase = 0;
    #(4*HALF_NS);
  endtask

  task automatic spi_bits(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
    rx = 8'hFF;
    for (int b = 7; b >= 8 - nbits; b--) begin
      sclk = 1'b0;
      mosi = tx[b];
      #(HALF_NS);
      rx[b] = miso;
      sclk = 1'b1;
      #(HALF_NS);
    end
  endtask

  // full byte: compare returned data with the model, using tag or the phase-derived one
  task automatic xfer(input logic [7:0] tx, input string tag);
    logic [7:0] rx;
    logic [7:0] exp;
    string t;
    exp = model_expect();
    t = (tag == "") ? phase_tag() : tag;
    spi_bits(tx, 8, rx);
    check(t, rx, exp);
    model_apply(tx);
  endtask

  task automatic abort_bits(input logic [7:0] tx, input int nbits);
    logic [7:0] rx;
    spi_bits(tx, nbits, rx);
    cs_n = 1'b1;
    mphase = 0;
    #(4*HALF_NS);
  endtask

  initial begin
    #(WD_NS);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) model_mem[i] = 8'h00;
    void'($urandom(32'h5EED_0042));
    #51;
    rst_n = 1'b1;
    #(2*HALF_NS);

    // R1: reset state
    check("R1", {7'h00, miso}, 8'h01);
    frame_begin();
    xfer(8'h7F, "R1");
    for (int i = 0; i < 4; i++) xfer(8'h00, "R1");
    frame_end();
    check("R1", {7'h00, miso}, 8'h01);

    // R3 R4 R2: set pointer, write edge-bit patterns
    frame_begin();
    xfer(8'h7D, ""); xfer(8'h10, "R3");
    frame_end();
    frame_begin();
    xfer(8'h7E, "");
    xfer(8'h80, ""); xfer(8'h01, ""); xfer(8'hA5, "");
    frame_end();
    check("R2", {7'h00, miso}, 8'h01);
    // R3: set pointer then command in the same selection
    frame_begin();
    xfer(8'h7D, ""); xfer(8'h10, "R3");
    xfer(8'h7F, "R3");
    xfer(8'h00, "R2"); xfer(8'h00, "R2"); xfer(8'h00, "R5");
    frame_end();

    // R7: wrap
    frame_begin();
    xfer(8'h7D, ""); xfer(8'hFE, "R7");
    xfer(8'h7E, ""); xfer(8'h11, ""); xfer(8'h22, ""); xfer(8'h33, "");
    frame_end();
    frame_begin();
    xfer(8'h7D, ""); xfer(8'hFE, "R7");
    xfer(8'h7F, "");
    xfer(8'h00, "R7"); xfer(8'h00, "R7"); xfer(8'h00, "R7");
    frame_end();

    // R8: pointer clear
    frame_begin();
    xfer(8'h7D, ""); xfer(8'h12, "");
    xfer(8'h7A, "R8");
    xfer(8'h7F, "R8");
    xfer(8'h00, "R8"); xfer(8'h00, "R8");
    frame_end();

    // R9: unknown codes
    frame_begin();
    xfer(8'h7D, ""); xfer(8'h10, "");
    xfer(8'h00, "R9"); xfer(8'h55, "R9"); xfer(8'h7B, "R9");
    xfer(8'hFF, "R9"); xfer(8'h7C, "R9"); xfer(8'h80, "R9");
    xfer(8'h7F, "R9");
    xfer(8'h00, "R9"); xfer(8'h00, "R9");
    frame_end();

    // R10: abort mid-byte in write stream, pointer kept across selections
    frame_begin();
    xfer(8'h7D, ""); xfer(8'h20, "");
    xfer(8'h7E, "");
    abort_bits(8'hC3, 4);
    frame_begin();
    xfer(8'h7F, "R10");
    xfer(8'h00, "R10");
    frame_end();
    check("R10", {7'h00, miso}, 8'h01);
    // R10: abort a command byte, then a full command works
    frame_begin();
    abort_bits(8'h7E, 5);
    frame_begin();
    xfer(8'h7D, "R10"); xfer(8'h10, "R10");
    xfer(8'h7F, "R10"); xfer(8'h00, "R10");
    frame_end();

    // random frames
    for (int f = 0; f < 120; f++) begin
      int sel;
      int nb;
      logic [7:0] op;
      sel = int'($urandom % 10);
      if (sel < 3) op = 8'h7E;
      else if (sel < 6) op = 8'h7F;
      else if (sel < 8) op = 8'h7D;
      else if (sel == 8) op = 8'h7A;
      else op = 8'($urandom);
      frame_begin();
      xfer(op, "");
      nb = int'($urandom % 5);
      for (int k = 0; k < nb; k++) xfer(8'($urandom), "");
      if ($urandom % 8 == 0) abort_bits(8'($urandom), 1 + int'($urandom % 7));
      else frame_end();
      check("R2", {7'h00, miso}, 8'h01);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule